// File: doc/BRIEF.md
# Pipelined Bus Register-File Target with Wait States

This block is a memory-mapped target on a pipelined AHB-style bus. It holds a small array of data words that a bus master reads and writes. Every transfer has an address cycle followed by a data cycle. The target registers the address-cycle controls only in a cycle where it is selected and the bus-wide ready input is high. If another target is still stalling the bus, this target therefore waits for that transfer to end before it starts its own.

A 3-bit wait-count input sets how long each accepted transfer is stretched. For that many cycles the target holds its ready output low, and then it completes. Write data is taken in the completing cycle, with byte lanes chosen by the transfer size and the low address bits. Read data is driven only in the completing cycle. While a data cycle finishes, the next address cycle can already be on the bus, so back-to-back transfers run without a gap.

Top module: `ahb_wait_slave`

## Requirements
- R1: After reset the ready output is high, the response output is 0 (OKAY) and the read-data output is zero.
- R2: A transfer is accepted only in a cycle where the select input and the ready input are both high and the transfer type is 2'b10 (first beat) or 2'b11 (sequential beat). A transfer type of 2'b10 presented without select leaves the ready output high and writes nothing.
- R3: While the ready input is low, a selected first-beat transfer is not accepted. The ready output stays high and nothing is written. The transfer is accepted at the first rising clock edge after the ready input returns high.
- R4: Transfer types 2'b00 (idle) and 2'b01 (busy) get a zero-wait OKAY. The ready output stays high in the following cycle and no array word changes.
- R5: After an accepted transfer with wait count N (0 to 7), the ready output is low for exactly N cycles and then high for the completing cycle.
- R6: A write is committed at the end of its completing cycle. Size 0 writes the byte at lane addr[1:0]. Size 1 writes the halfword at lanes 2*addr[1] and 2*addr[1]+1. Size 2 writes all four lanes. Lane k holds bits 8k+7:8k of the word at index addr[5:2].
- R7: The read-data output carries the addressed word in the completing cycle of a read, and is zero in every cycle where the ready output is low.
- R8: An address cycle presented during a data cycle's completing cycle is accepted at that edge. Its data cycle follows with no idle cycle between, and a read issued right after a write to the same word returns the new data.
- R9: The response output is 0 (OKAY) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Target select for the current address cycle |
| addr | input | 6 | Byte address |
| trans | input | 2 | Transfer type (00 idle, 01 busy, 10 first beat, 11 sequential) |
| write | input | 1 | 1 for a write, 0 for a read |
| size | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| wdata | input | 32 | Write data, valid in the data cycle |
| readyIn | input | 1 | Bus-wide ready, high when the current data cycle completes |
| waitCfg | input | 3 | Number of wait states for the next accepted transfer |
| readyOut | output | 1 | Low while this target stretches its data cycle |
| rdata | output | 32 | Read data |
| resp | output | 1 | Transfer response, always OKAY |

## Verification
The bench builds the target with its default geometry: sixteen 32-bit words, which gives a 6-bit byte address with four byte lanes. At this size every lane and size combination can be reached with a handful of addresses. The bench sweeps the wait-count input over 0, 1, 3 and 7, so both the shortest data cycle and the longest stall are covered. It also models a neighbouring target that holds the bus-wide ready low for several cycles, and it drives a read straight after a write to the same word.

// File: rtl/ahb_wait_pkg.sv
package ahb_wait_pkg;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_FIRST  = 2'b10;
  localparam logic [1:0] TR_FOLLOW = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // register address-cycle controls this edge
    logic commit;   // write data lands this edge
    logic readOut;  // drive the addressed word on the read bus
  } strobe_t;

  function automatic logic startsData(input logic [1:0] tr);
    return (tr == TR_FIRST) || (tr == TR_FOLLOW);
  endfunction

endpackage

// File: rtl/ahb_wait_ctrl.sv
module ahb_wait_ctrl
  import ahb_wait_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic              readyIn,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic              readyOut,
  output strobe_t           strb
);

  logic              active;
  logic              pendWrite;
  logic [WAIT_W-1:0] waitLeft;
  logic              busyHold;
  logic              take;

  assign busyHold = active && (waitLeft != '0);
  assign take     = sel && readyIn && startsData(trans) && !busyHold;
  assign readyOut = !busyHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      pendWrite <= 1'b0;
      waitLeft  <= '0;
    end else if (busyHold) begin
      waitLeft <= waitLeft - 1'b1;
    end else begin
      active <= take;
      if (take) begin
        pendWrite <= write;
        waitLeft  <= waitCfg;
      end
    end
  end

  always_comb begin
    strb.capture = take;
    strb.commit  = active && pendWrite && !busyHold;
    strb.readOut = active && !pendWrite && !busyHold;
  end

endmodule

// File: rtl/ahb_wait_dp.sv
module ahb_wait_dp
  import ahb_wait_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = LANE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idxQ;
  logic [LANES-1:0]  laneQ;
  logic [LANES-1:0]  laneNext;
  int                nBytes;

  always_comb begin
    nBytes = 1 << int'(size);
    if (nBytes > LANES) nBytes = LANES;
    laneNext = '0;
    for (int b = 0; b < LANES; b++) begin
      if ((b / nBytes) == (int'(addr[LANE_W-1:0]) / nBytes)) laneNext[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      laneQ <= '0;
    end else if (strb.capture) begin
      idxQ  <= addr[ADDR_W-1:LANE_W];
      laneQ <= laneNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (strb.commit) begin
      for (int b = 0; b < LANES; b++) begin
        if (laneQ[b]) mem[idxQ][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = strb.readOut ? mem[idxQ] : '0;

endmodule

// File: rtl/ahb_wait_slave.sv
module ahb_wait_slave
  import ahb_wait_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 3,
  localparam int ADDR_W = $clog2(DATA_W / 8) + $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  input  logic              readyIn,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic              readyOut,
  output logic [DATA_W-1:0] rdata,
  output logic              resp
);

  strobe_t strb;

  ahb_wait_ctrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sel(sel), .trans(trans), .write(write),
    .readyIn(readyIn), .waitCfg(waitCfg), .readyOut(readyOut), .strb(strb)
  );

  ahb_wait_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata)
  );

  assign resp = 1'b0;

endmodule

// File: rtl/ahb_wait_slave_chk.sv
module ahb_wait_slave_chk #(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic [1:0]        trans,
  input logic              readyIn,
  input logic [WAIT_W-1:0] waitCfg,
  input logic              readyOut,
  input logic [DATA_W-1:0] rdata
);

  // R3
  stall_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel && !readyIn && readyOut |=> readyOut);

  // R4
  idle_zero_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel && readyIn && readyOut && !trans[1] |=> readyOut);

  // R5
  wait_begins_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel && readyIn && readyOut && trans[1] && (waitCfg != '0) |=> !readyOut);

  // R5
  no_wait_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel && readyIn && readyOut && trans[1] && (waitCfg == '0) |=> readyOut);

  // R7
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> rdata == '0);

endmodule

bind ahb_wait_slave ahb_wait_slave_chk #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) uChk (
  .clk(clk), .rstN(rstN), .sel(sel), .trans(trans), .readyIn(readyIn),
  .waitCfg(waitCfg), .readyOut(readyOut), .rdata(rdata)
);

// File: tb/tb_ahb_wait_slave.sv
module tb_ahb_wait_slave;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic [5:0]  addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [31:0] wdata = '0;
  logic        readyIn;
  logic [2:0]  waitCfg = '0;
  logic        readyOut;
  logic [31:0] rdata;
  logic        resp;
  logic        otherStall = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  // bus ready mux: a neighbour target can hold the bus
  assign readyIn = otherStall ? 1'b0 : readyOut;

  ahb_wait_slave dut (
    .clk(clk), .rstN(rstN), .sel(sel), .addr(addr), .trans(trans),
    .write(write), .size(size), .wdata(wdata), .readyIn(readyIn),
    .waitCfg(waitCfg), .readyOut(readyOut), .rdata(rdata), .resp(resp)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [5:0] a, input logic [2:0] sz, input logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      bit hit;
      case (sz)
        3'd0: hit = (k == int'(a[1:0]));
        3'd1: hit = ((k / 2) == int'(a[1]));
        default: hit = 1'b1;
      endcase
      if (hit) model[a[5:2]][8*k +: 8] = d[8*k +: 8];
    end
  endtask

  task automatic idleBus();
    sel = 1'b0; trans = 2'b00; write = 1'b0;
  endtask

  // write with optional neighbour stall before acceptance; checks R3 R5 R6
  task automatic doWrite(input logic [5:0] a, input logic [2:0] sz, input logic [31:0] d,
                         input logic [2:0] w, input int stall);
    int lows = 0;
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b1; addr = a; size = sz; waitCfg = w;
    otherStall = (stall > 0);
    for (int i = 0; i < stall; i++) begin
      check(readyOut == 1'b1, "R3 ready during neighbour stall", {31'd0, readyOut}, 32'd1);
      @(posedge clk); @(negedge clk);
    end
    otherStall = 1'b0;
    @(posedge clk); @(negedge clk);
    idleBus(); wdata = d;
    while (!readyOut && lows < 20) begin
      check(rdata == 32'd0, "R7 rdata zero in wait", rdata, 32'd0);
      lows++;
      @(posedge clk); @(negedge clk);
    end
    check(lows == int'(w), "R5 wait count", lows, {29'd0, w});
    @(posedge clk);
    modelWrite(a, sz, d);
  endtask

  task automatic doRead(input logic [5:0] a, input logic [2:0] w, input string tag);
    int lows = 0;
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b0; addr = a; size = 3'd2; waitCfg = w;
    @(posedge clk); @(negedge clk);
    idleBus();
    while (!readyOut && lows < 20) begin
      check(rdata == 32'd0, "R7 rdata zero in wait", rdata, 32'd0);
      lows++;
      @(posedge clk); @(negedge clk);
    end
    check(lows == int'(w), "R5 read wait count", lows, {29'd0, w});
    check(rdata == model[a[5:2]], tag, rdata, model[a[5:2]]);
    check(resp == 1'b0, "R9 resp okay", {31'd0, resp}, 32'd0);
    @(posedge clk);
  endtask

  task automatic testReset();
    check(readyOut == 1'b1, "R1 reset ready", {31'd0, readyOut}, 32'd1);
    check(resp == 1'b0, "R1 reset resp", {31'd0, resp}, 32'd0);
    check(rdata == 32'd0, "R1 reset rdata", rdata, 32'd0);
  endtask

  task automatic testWords();
    doWrite(6'h04, 3'd2, 32'hCAFE_0001, 3'd0, 0);
    doRead(6'h04, 3'd0, "R6 R7 word read back");
    doWrite(6'h08, 3'd2, 32'h1234_5678, 3'd3, 0);
    doRead(6'h08, 3'd1, "R5 R7 word with waits");
    doWrite(6'h3C, 3'd2, 32'hDEAD_BEEF, 3'd7, 0);
    doRead(6'h3C, 3'd7, "R5 max wait read");
  endtask

  task automatic testLanes();
    doWrite(6'h10, 3'd2, 32'h0000_0000, 3'd0, 0);
    doWrite(6'h11, 3'd0, 32'hAAAA_AAAA, 3'd1, 0);
    doWrite(6'h13, 3'd0, 32'h5555_5555, 3'd0, 0);
    doRead(6'h10, 3'd0, "R6 byte lanes 1 and 3");
    doWrite(6'h12, 3'd1, 32'h9876_1111, 3'd2, 0);
    doRead(6'h10, 3'd0, "R6 upper halfword");
  endtask

  task automatic testIgnored();
    @(negedge clk);
    sel = 1'b1; write = 1'b1; addr = 6'h04; size = 3'd2; waitCfg = 3'd5; wdata = 32'hFFFF_FFFF;
    trans = 2'b00;
    @(posedge clk); @(negedge clk);
    check(readyOut == 1'b1, "R4 idle zero wait", {31'd0, readyOut}, 32'd1);
    trans = 2'b01;
    @(posedge clk); @(negedge clk);
    check(readyOut == 1'b1, "R4 busy zero wait", {31'd0, readyOut}, 32'd1);
    sel = 1'b0; trans = 2'b10;
    @(posedge clk); @(negedge clk);
    check(readyOut == 1'b1, "R2 unselected ignored", {31'd0, readyOut}, 32'd1);
    idleBus();
    @(posedge clk);
    doRead(6'h04, 3'd0, "R2 R4 word unchanged");
  endtask

  task automatic testNeighbourStall();
    doWrite(6'h20, 3'd2, 32'h0BAD_F00D, 3'd2, 3);
    doRead(6'h20, 3'd0, "R3 write after neighbour stall");
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b1; addr = 6'h28; size = 3'd2; waitCfg = 3'd1;
    @(posedge clk); @(negedge clk);
    wdata = 32'h7777_2222;
    trans = 2'b11; write = 1'b0; waitCfg = 3'd0;
    check(readyOut == 1'b0, "R8 first data cycle waits", {31'd0, readyOut}, 32'd0);
    @(posedge clk); @(negedge clk);
    check(readyOut == 1'b1, "R8 write completing", {31'd0, readyOut}, 32'd1);
    @(posedge clk); @(negedge clk);
    modelWrite(6'h28, 3'd2, 32'h7777_2222);
    idleBus();
    check(readyOut == 1'b1, "R8 pipelined read ready", {31'd0, readyOut}, 32'd1);
    check(rdata == 32'h7777_2222, "R8 read after write", rdata, 32'h7777_2222);
    @(posedge clk); @(negedge clk);
    check(rdata == 32'd0, "R7 rdata zero when idle", rdata, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWords();
    testLanes();
    testIgnored();
    testNeighbourStall();
    testBackToBack();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule